// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the lookup path of a set-associative cache. The set index comes only from the untranslated page-offset bits of a virtual address. A request therefore starts the read of every way in the same cycle that the TLB starts translating the address. One cycle later the block holds a registered copy of each way's valid bit, physical tag and line. It then waits in a holding state until the TLB returns its physical page number. In that cycle it compares the held tags against the page number and reports hit, way and line.

Lines enter through a fill port that names a set, a physical tag and the line contents. The way that receives a fill comes from a round-robin pointer kept for each set. The controller has two states. `ST_IDLE` accepts a request; the transition from `ST_IDLE` to `ST_WAIT` is called *accept*. `ST_WAIT` holds the array snapshot and waits for the TLB; the transition from `ST_WAIT` back to `ST_IDLE` is called *resolve* and happens in the cycle the TLB result is valid.

Top module: `vipt_lookup`

## Requirements
- R1: The set index is `req_vaddr[11:4]`, the page-offset bits above the 4-bit block offset. Bits 31:12 and 3:0 of the address have no effect on which line is found.
- R2: `req_ready` is high in `ST_IDLE`. A request with `req_valid` high while `req_ready` is high is accepted, and `req_ready` stays low until the cycle after the response.
- R3: `resp_valid` is high only in `ST_WAIT` and only in a cycle where `tlb_valid` is high. The earliest response comes one cycle after acceptance. The TLB may take any number of further cycles, and during those cycles `resp_valid` stays low.
- R4: A hit requires a way whose valid bit is set and whose stored physical tag equals `tlb_ppn`. On a hit, `resp_way` gives that way and `resp_line` gives its stored line.
- R5: When `tlb_hit` is low in the response cycle, `resp_hit` is low and `resp_line` is zero, whatever the array holds.
- R6: When no valid way matches, `resp_hit` is low and `resp_line` is zero.
- R7: A fill writes its tag and line into the way chosen by the pointer of set `fill_idx` and marks that way valid. The pointer then advances by one, wrapping after the last way. Pointers of other sets do not change. After reset every pointer selects way 0.
- R8: After reset every way of every set is invalid, so every lookup misses.
- R9: Lines in different ways of the same set, with different physical tags, are resident at the same time. The capacity is therefore W times 2^12 bytes.
- R10: A lookup compares against the array contents as they were at the accept edge. A fill made after acceptance, while the lookup waits for the TLB, is not visible to that lookup but is visible to the next one.
- R11: A fill into a set whose ways are all valid evicts the way the pointer selects, which is the way that was filled longest ago.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Controller can accept a request |
| req_vaddr | input | 32 | Virtual address of the request |
| tlb_valid | input | 1 | TLB result present this cycle |
| tlb_hit | input | 1 | TLB found a translation |
| tlb_ppn | input | 20 | Physical page number from the TLB |
| fill_valid | input | 1 | Write a line this cycle |
| fill_idx | input | 8 | Set receiving the fill |
| fill_ptag | input | 20 | Physical tag of the filled line |
| fill_line | input | 128 | Line contents |
| resp_valid | output | 1 | Lookup result present |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 1 | Way that hit |
| resp_line | output | 128 | Line that hit, zero otherwise |

## Verification
The bench uses the default build: a 12-bit page offset, a 4-bit block offset and two ways. That gives 256 sets, small enough to fill both ways of every set and probe each one. For every set the bench probes each resident tag, an absent tag, and a tag presented with the TLB reporting a miss. The TLB delay differs from set to set, and the bits outside the index are randomised. With only two ways, the wrap of the round-robin pointer and the eviction of the older line are both reached after a few fills to one set. The test where a fill lands while a lookup is waiting is also run.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lk_state_e;

endpackage

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_vld_q,
    output logic [TAG_W-1:0]  rd_tag_q,
    output logic [LINE_W-1:0] rd_line_q,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    // Valid bits are the only part of the store that needs a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    // Read register: it captures the contents before any write on the same
    // edge, and keeps them until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_q  <= 1'b0;
            rd_tag_q  <= '0;
            rd_line_q <= '0;
        end else if (rd_en) begin
            rd_vld_q  <= vld[rd_idx];
            rd_tag_q  <= tag_mem[rd_idx];
            rd_line_q <= line_mem[rd_idx];
        end
    end

endmodule

// File: rtl/vipt_rr_victim.sv
module vipt_rr_victim #(
    parameter int IDX_W = 8,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    output logic [WAY_W-1:0] victim
);
    localparam int SETS = 1 << IDX_W;
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] ptr [SETS];

    assign victim = ptr[fill_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ptr[s] <= '0;
            end
        end else if (fill_en) begin
            if (ptr[fill_idx] == LAST_WAY) begin
                ptr[fill_idx] <= '0;
            end else begin
                ptr[fill_idx] <= ptr[fill_idx] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vipt_tag_match.sv
module vipt_tag_match #(
    parameter int WAYS   = 2,
    parameter int WAY_W  = 1,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 128
) (
    input  logic [WAYS-1:0]             way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][LINE_W-1:0] way_line,
    input  logic [TAG_W-1:0]            ppn,
    output logic                        any_hit,
    output logic [WAY_W-1:0]            hit_way,
    output logic [LINE_W-1:0]           hit_line
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_vld[w] && (way_tag[w] == ppn);
    end

    // The loop runs from the highest way down, so the lowest matching way wins.
    always_comb begin
        any_hit  = 1'b0;
        hit_way  = '0;
        hit_line = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                any_hit  = 1'b1;
                hit_way  = WAY_W'(w);
                hit_line = way_line[w];
            end
        end
    end

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_OFF_W = 12,
    parameter int BLK_OFF_W  = 4,
    parameter int WAYS       = 2,
    parameter int PPN_W      = 20
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic [VA_W-1:0]                         req_vaddr,
    input  logic                                    tlb_valid,
    input  logic                                    tlb_hit,
    input  logic [PPN_W-1:0]                        tlb_ppn,
    input  logic                                    fill_valid,
    input  logic [PAGE_OFF_W-BLK_OFF_W-1:0]         fill_idx,
    input  logic [PPN_W-1:0]                        fill_ptag,
    input  logic [(8<<BLK_OFF_W)-1:0]               fill_line,
    output logic                                    resp_valid,
    output logic                                    resp_hit,
    output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]    resp_way,
    output logic [(8<<BLK_OFF_W)-1:0]               resp_line
);
    localparam int IDX_W  = PAGE_OFF_W - BLK_OFF_W;
    localparam int LINE_W = 8 << BLK_OFF_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

    lk_state_e state_q, state_d;
    logic      accept;

    logic [IDX_W-1:0]             set_idx;
    logic [WAY_W-1:0]             victim;
    logic [WAYS-1:0]              rd_vld;
    logic [WAYS-1:0][PPN_W-1:0]   rd_tag;
    logic [WAYS-1:0][LINE_W-1:0]  rd_line;
    logic                         any_hit;
    logic [WAY_W-1:0]             hit_way;
    logic [LINE_W-1:0]            hit_line;
    logic                         unused_va_bits;

    // The index lies entirely inside the page offset, so no translated bit is needed.
    assign set_idx        = req_vaddr[PAGE_OFF_W-1:BLK_OFF_W];
    assign unused_va_bits = ^{req_vaddr[VA_W-1:PAGE_OFF_W], req_vaddr[BLK_OFF_W-1:0]};
    assign accept         = req_valid && (state_q == ST_IDLE);

    vipt_rr_victim #(
        .IDX_W (IDX_W),
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .victim   (victim)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way_store #(
            .IDX_W  (IDX_W),
            .TAG_W  (PPN_W),
            .LINE_W (LINE_W)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_en     (accept),
            .rd_idx    (set_idx),
            .rd_vld_q  (rd_vld[w]),
            .rd_tag_q  (rd_tag[w]),
            .rd_line_q (rd_line[w]),
            .wr_en     (fill_valid && (victim == WAY_W'(w))),
            .wr_idx    (fill_idx),
            .wr_tag    (fill_ptag),
            .wr_line   (fill_line)
        );
    end

    vipt_tag_match #(
        .WAYS   (WAYS),
        .WAY_W  (WAY_W),
        .TAG_W  (PPN_W),
        .LINE_W (LINE_W)
    ) u_match (
        .way_vld  (rd_vld),
        .way_tag  (rd_tag),
        .way_line (rd_line),
        .ppn      (tlb_ppn),
        .any_hit  (any_hit),
        .hit_way  (hit_way),
        .hit_line (hit_line)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: accept (IDLE to WAIT), resolve (WAIT to IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_WAIT;
            ST_WAIT: if (tlb_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_way   = '0;
        resp_line  = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_WAIT: begin
                if (tlb_valid) begin
                    resp_valid = 1'b1;
                    if (tlb_hit && any_hit) begin
                        resp_hit  = 1'b1;
                        resp_way  = hit_way;
                        resp_line = hit_line;
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk #(
    parameter int LINE_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              tlb_valid,
    input logic              tlb_hit,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [LINE_W-1:0] resp_line
);

    assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_release_after_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> req_ready);

    assert_resp_needs_tlb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (tlb_valid && !req_ready));

    assert_hit_inside_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> resp_valid);

    assert_tlb_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !tlb_hit) |-> (!resp_hit && resp_line == '0));

    assert_miss_line_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_line == '0));

endmodule

bind vipt_lookup vipt_lookup_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/sim_vipt_lookup.sv
module sim_vipt_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int SETS       = 256;
    localparam int LINE_W     = 128;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_vaddr;
    logic         tlb_valid;
    logic         tlb_hit;
    logic [19:0]  tlb_ppn;
    logic         fill_valid;
    logic [7:0]   fill_idx;
    logic [19:0]  fill_ptag;
    logic [127:0] fill_line;
    logic         resp_valid;
    logic         resp_hit;
    logic [0:0]   resp_way;
    logic [127:0] resp_line;

    int n_tests = 0;
    int n_fail  = 0;

    logic [19:0] m_tag [SETS][2];
    bit          m_vld [SETS][2];
    int          m_ptr [SETS];

    vipt_lookup u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [127:0] line_of(int s, logic [19:0] t);
        return {4{8'(s), 4'h0, t}};
    endfunction

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_fill(int s, logic [19:0] t);
        int w;
        w = m_ptr[s];
        m_tag[s][w] = t;
        m_vld[s][w] = 1'b1;
        m_ptr[s] = (w + 1) % 2;
    endtask

    task automatic do_fill(int s, logic [19:0] t);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_idx   = 8'(s);
        fill_ptag  = t;
        fill_line  = line_of(s, t);
        model_fill(s, t);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_lookup(int s, logic [19:0] ppn, bit th, int extra,
                             bit mid_fill, logic [19:0] mf_tag, string req);
        bit           eh = 1'b0;
        int           ew = 0;
        logic [127:0] ed = '0;
        if (th) begin
            for (int w = 0; w < 2; w++) begin
                if (!eh && m_vld[s][w] && m_tag[s][w] == ppn) begin
                    eh = 1'b1;
                    ew = w;
                    ed = line_of(s, ppn);
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {20'($urandom), 8'(s), 4'($urandom)};
        tlb_valid = 1'b0;
        #1;
        check("R2", "ready before accept", 128'(req_ready), 128'(1));
        check("R3", "no resp in idle", 128'(resp_valid), 128'(0));
        @(negedge clk);
        req_valid = 1'b0;
        if (mid_fill) begin
            fill_valid = 1'b1;
            fill_idx   = 8'(s);
            fill_ptag  = mf_tag;
            fill_line  = line_of(s, mf_tag);
            model_fill(s, mf_tag);
        end
        for (int i = 0; i < extra; i++) begin
            #1;
            check("R3", "no resp while tlb busy", 128'(resp_valid), 128'(0));
            check("R2", "not ready while waiting", 128'(req_ready), 128'(0));
            @(negedge clk);
            fill_valid = 1'b0;
        end
        tlb_valid = 1'b1;
        tlb_hit   = th;
        tlb_ppn   = ppn;
        #1;
        check("R3", "resp with tlb", 128'(resp_valid), 128'(1));
        check(req, "hit", 128'(resp_hit), 128'(eh));
        if (eh) check(req, "way", 128'(resp_way), 128'(ew));
        check(req, "line", resp_line, ed);
        @(negedge clk);
        tlb_valid  = 1'b0;
        fill_valid = 1'b0;
        #1;
        check("R2", "ready after resp", 128'(req_ready), 128'(1));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [19:0] ta, tb, tc, td;
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_vld[s][w] = 1'b0;
                m_tag[s][w] = '0;
            end
        end
        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; tlb_valid = 1'b0;
        tlb_hit = 1'b0; tlb_ppn = '0; fill_valid = 1'b0; fill_idx = '0;
        fill_ptag = '0; fill_line = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2", "reset ready", 128'(req_ready), 128'(1));
        check("R8", "reset no resp", 128'(resp_valid), 128'(0));

        // R8: empty cache misses, even on tag value zero
        do_lookup(0, 20'h0, 1'b1, 0, 1'b0, '0, "R8");
        do_lookup(3, 20'h0, 1'b1, 2, 1'b0, '0, "R8");

        // R10: fill while waiting is invisible, then visible
        do_lookup(200, 20'h12345, 1'b1, 1, 1'b1, 20'h12345, "R10");
        do_lookup(200, 20'h12345, 1'b1, 0, 1'b0, '0, "R10");

        // R1 R4 R5 R6 R9: full sweep
        for (int s = 0; s < SETS; s++) begin
            do_fill(s, 20'(s * 7 + 1));
            do_fill(s, 20'h80000 | 20'(s));
        end
        for (int s = 0; s < SETS; s++) begin
            ta = 20'(s * 7 + 1);
            tb = 20'h80000 | 20'(s);
            do_lookup(s, ta, 1'b1, s % 3, 1'b0, '0, "R9");
            do_lookup(s, tb, 1'b1, (s + 1) % 3, 1'b0, '0, "R4");
            do_lookup(s, 20'hFFFFF, 1'b1, s % 2, 1'b0, '0, "R6");
            do_lookup(s, ta, 1'b0, 0, 1'b0, '0, "R5");
        end

        // R7 R11: eviction order on set 5, set 6 untouched
        ta = 20'(5 * 7 + 1);
        tb = 20'h80005;
        tc = 20'h30005;
        td = 20'h40005;
        do_fill(5, tc);
        do_lookup(5, ta, 1'b1, 0, 1'b0, '0, "R11");
        do_lookup(5, tc, 1'b1, 1, 1'b0, '0, "R7");
        do_lookup(5, tb, 1'b1, 0, 1'b0, '0, "R7");
        do_fill(5, td);
        do_lookup(5, tb, 1'b1, 0, 1'b0, '0, "R11");
        do_lookup(5, td, 1'b1, 2, 1'b0, '0, "R7");
        do_lookup(6, 20'(6 * 7 + 1), 1'b1, 0, 1'b0, '0, "R7");
        do_lookup(6, 20'h80006, 1'b1, 0, 1'b0, '0, "R7");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule